// File: doc/BRIEF.md
# USB Host Port Over-Current Status

This block holds the over-current and port-power state of one USB 2.0 host port. Off-chip detection logic raises an over-current indication. The block brings that signal into the clock domain and tracks it in a two-state machine. On every change of the condition it records a sticky change flag. When the condition starts, it takes the port out of service. The change flag also feeds a controller-wide port-change flag, which can be routed to an interrupt.

The state machine has two states. `OC_NORMAL` means no over-current is present, and `OC_FAULT` means over-current is present. Transition `fault_seen` (`OC_NORMAL` to `OC_FAULT`) fires when the synchronized input is high. Transition `fault_gone` (`OC_FAULT` to `OC_NORMAL`) fires when the synchronized input is low. Each transition is a change event.

Software writes to the port enable and port power bits through separate strobes. It clears the two change flags with one-cycle write-one strobes. A build parameter chooses whether over-current also removes port power or leaves power applied and relies on external current limiting.

Top module: `usb_port_ocp`

## Requirements
- R1: On a clock edge with `rst_n` low, `oca_o`, `occ_o`, `pe_o`, `pp_o`, `pcd_o`, `ppe_o` and `irq_o` all become 0.
- R2: `oca_o` follows `oc_ext_i` through two synchronizer flops and the state register. A level change on `oc_ext_i` made before clock edge 1 appears on `oca_o` after edge 3 and not before.
- R3: `occ_o` becomes 1 on the same edge at which `oca_o` changes, for both the 0-to-1 and the 1-to-0 change.
- R4: `occ_o` stays 1 until a cycle with `occ_clr_i` high, which clears it. Cycles without the strobe leave it unchanged. If a change event and the strobe fall on the same edge, `occ_o` ends at 1.
- R5: On the edge where `oca_o` rises, `pe_o` is cleared. While `oca_o` is 1, a write with `pe_wr_i`=1 and `pe_wdata_i`=1 leaves `pe_o` at 0. Otherwise `pe_wr_i` loads `pe_wdata_i`.
- R6: `pcd_o` is set on an edge where `occ_o` goes from 0 to 1. It is not set by a change event while `occ_o` is already 1. `pcd_clr_i` clears it, and a set on the same edge wins.
- R7: `irq_o` equals `pcd_o` AND `pce_i` with no register delay.
- R8: With `CLEAR_PP_ON_OC`=1, `pp_o` is cleared on the edge where `oca_o` rises. With `CLEAR_PP_ON_OC`=0, over-current leaves `pp_o` unchanged. Apart from that, `pp_wr_i` loads `pp_wdata_i`.
- R9: `ppe_o` = `pp_o` AND (NOT `cap_ppc_i` OR `cfg_flag_i`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oc_ext_i | input | 1 | Asynchronous over-current indication from off-chip |
| cap_ppc_i | input | 1 | Capability: port power switch present |
| cfg_flag_i | input | 1 | Controller configured flag |
| pce_i | input | 1 | Port-change interrupt enable |
| pe_wr_i | input | 1 | Write strobe for the port enable bit |
| pe_wdata_i | input | 1 | Value written to the port enable bit |
| pp_wr_i | input | 1 | Write strobe for the port power bit |
| pp_wdata_i | input | 1 | Value written to the port power bit |
| occ_clr_i | input | 1 | Write-one clear of the over-current change bit |
| pcd_clr_i | input | 1 | Write-one clear of the port-change flag |
| oca_o | output | 1 | Over-current active |
| occ_o | output | 1 | Over-current change (sticky) |
| pe_o | output | 1 | Port enabled |
| pp_o | output | 1 | Port power bit |
| ppe_o | output | 1 | Port power switch enable |
| pcd_o | output | 1 | Controller-wide port-change flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds two copies of the block that share the same stimulus. One uses `CLEAR_PP_ON_OC`=1 and the other uses 0, so both power policies are seen under one identical over-current sequence. Both copies use the default two-stage synchronizer. This makes the exact three-edge latency from input to status observable and lets the bench place clear strobes on the very edge where a change event lands.

// File: rtl/usb_ocp_pkg.sv
package usb_ocp_pkg;

    // Over-current tracking states
    typedef enum logic {
        OC_NORMAL = 1'b0,
        OC_FAULT  = 1'b1
    } oc_state_e;

    localparam int unsigned OC_MIN_SYNC = 1;

endpackage

// File: rtl/usb_ocp_sync.sv
module usb_ocp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[LAST-1:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[LAST];

endmodule

// File: rtl/usb_ocp_fsm.sv
module usb_ocp_fsm
    import usb_ocp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic oc_sync_i,
    output logic oca_o,
    output logic rise_evt_o,
    output logic fall_evt_o
);

    oc_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OC_NORMAL;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        oca_o      = 1'b0;
        rise_evt_o = 1'b0;
        fall_evt_o = 1'b0;
        unique case (state_q)
            OC_NORMAL: begin
                if (oc_sync_i) begin        // fault_seen
                    state_d    = OC_FAULT;
                    rise_evt_o = 1'b1;
                end
            end
            OC_FAULT: begin
                oca_o = 1'b1;
                if (!oc_sync_i) begin       // fault_gone
                    state_d    = OC_NORMAL;
                    fall_evt_o = 1'b1;
                end
            end
            default: state_d = OC_NORMAL;
        endcase
    end

endmodule

// File: rtl/usb_ocp_regs.sv
module usb_ocp_regs #(
    parameter bit CLEAR_PP_ON_OC = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oca_i,
    input  logic rise_evt_i,
    input  logic fall_evt_i,
    input  logic pe_wr_i,
    input  logic pe_wdata_i,
    input  logic pp_wr_i,
    input  logic pp_wdata_i,
    input  logic occ_clr_i,
    input  logic pcd_clr_i,
    output logic occ_o,
    output logic pe_o,
    output logic pp_o,
    output logic pcd_o
);

    logic occ_q, pe_q, pp_q, pcd_q;
    logic chg_evt, pcd_set, pp_drop;

    assign chg_evt = rise_evt_i | fall_evt_i;
    assign pcd_set = chg_evt & ~occ_q;

    generate
        if (CLEAR_PP_ON_OC) begin : g_pp_cut
            assign pp_drop = rise_evt_i;
        end else begin : g_pp_keep
            assign pp_drop = 1'b0;
        end
    endgenerate

    // Change flag: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)         occ_q <= 1'b0;
        else if (chg_evt)   occ_q <= 1'b1;
        else if (occ_clr_i) occ_q <= 1'b0;
    end

    // Port-change flag: set on change-flag rise, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)         pcd_q <= 1'b0;
        else if (pcd_set)   pcd_q <= 1'b1;
        else if (pcd_clr_i) pcd_q <= 1'b0;
    end

    // Port enable: dropped on fault onset, writes of one blocked in fault
    always_ff @(posedge clk) begin
        if (!rst_n)          pe_q <= 1'b0;
        else if (rise_evt_i) pe_q <= 1'b0;
        else if (pe_wr_i && !(oca_i && pe_wdata_i))
                             pe_q <= pe_wdata_i;
    end

    // Port power
    always_ff @(posedge clk) begin
        if (!rst_n)       pp_q <= 1'b0;
        else if (pp_drop) pp_q <= 1'b0;
        else if (pp_wr_i) pp_q <= pp_wdata_i;
    end

    assign occ_o = occ_q;
    assign pe_o  = pe_q;
    assign pp_o  = pp_q;
    assign pcd_o = pcd_q;

endmodule

// File: rtl/usb_port_ocp.sv
module usb_port_ocp
    import usb_ocp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES    = 2,
    parameter bit          CLEAR_PP_ON_OC = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_ext_i,
    input  logic cap_ppc_i,
    input  logic cfg_flag_i,
    input  logic pce_i,
    input  logic pe_wr_i,
    input  logic pe_wdata_i,
    input  logic pp_wr_i,
    input  logic pp_wdata_i,
    input  logic occ_clr_i,
    input  logic pcd_clr_i,
    output logic oca_o,
    output logic occ_o,
    output logic pe_o,
    output logic pp_o,
    output logic ppe_o,
    output logic pcd_o,
    output logic irq_o
);

    localparam int unsigned N_SYNC = (SYNC_STAGES < OC_MIN_SYNC) ? OC_MIN_SYNC : SYNC_STAGES;

    logic oc_sync, oca, rise_evt, fall_evt;

    usb_ocp_sync #(.STAGES(N_SYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (oc_ext_i),
        .q_o   (oc_sync)
    );

    usb_ocp_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .oc_sync_i  (oc_sync),
        .oca_o      (oca),
        .rise_evt_o (rise_evt),
        .fall_evt_o (fall_evt)
    );

    usb_ocp_regs #(.CLEAR_PP_ON_OC(CLEAR_PP_ON_OC)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .oca_i      (oca),
        .rise_evt_i (rise_evt),
        .fall_evt_i (fall_evt),
        .pe_wr_i    (pe_wr_i),
        .pe_wdata_i (pe_wdata_i),
        .pp_wr_i    (pp_wr_i),
        .pp_wdata_i (pp_wdata_i),
        .occ_clr_i  (occ_clr_i),
        .pcd_clr_i  (pcd_clr_i),
        .occ_o      (occ_o),
        .pe_o       (pe_o),
        .pp_o       (pp_o),
        .pcd_o      (pcd_o)
    );

    assign oca_o = oca;
    assign ppe_o = pp_o & (~cap_ppc_i | cfg_flag_i);
    assign irq_o = pcd_o & pce_i;

endmodule

// File: rtl/usb_port_ocp_chk.sv
module usb_port_ocp_chk #(
    parameter bit CLEAR_PP_ON_OC = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic oca_o,
    input logic occ_o,
    input logic pe_o,
    input logic pp_o,
    input logic ppe_o,
    input logic pcd_o,
    input logic irq_o,
    input logic pce_i,
    input logic occ_clr_i,
    input logic pcd_clr_i
);

    // R3: any change of the active bit leaves the change bit set
    assert_occ_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (oca_o != $past(oca_o)) |-> occ_o);

    // R4: the change bit only falls after a clear strobe
    assert_occ_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(occ_o) |-> $past(occ_clr_i));

    // R5: port never enabled while over-current is active
    assert_pe_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        oca_o |-> !pe_o);

    // R6: rising change bit raises the port-change flag
    assert_pcd_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(occ_o) |-> pcd_o);

    // R6: the port-change flag only falls after its clear strobe
    assert_pcd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pcd_o) |-> $past(pcd_clr_i));

    // R7: interrupt needs its enable
    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pce_i);

    // R8: power removed at fault onset when so built
    assert_pp_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(oca_o) && CLEAR_PP_ON_OC) |-> !pp_o);

    // R9: switch enable requires the power bit
    assert_ppe_pp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ppe_o |-> pp_o);

endmodule

bind usb_port_ocp usb_port_ocp_chk #(.CLEAR_PP_ON_OC(CLEAR_PP_ON_OC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .oca_o     (oca_o),
    .occ_o     (occ_o),
    .pe_o      (pe_o),
    .pp_o      (pp_o),
    .ppe_o     (ppe_o),
    .pcd_o     (pcd_o),
    .irq_o     (irq_o),
    .pce_i     (pce_i),
    .occ_clr_i (occ_clr_i),
    .pcd_clr_i (pcd_clr_i)
);

// File: tb/test_usb_port_ocp.sv
module test_usb_port_ocp;

    logic clk = 1'b0;
    logic rst_n;
    logic oc_ext, cap_ppc, cfg_flag, pce;
    logic pe_wr, pe_wdata, pp_wr, pp_wdata, occ_clr, pcd_clr;

    logic oca, occ, pe, pp, ppe, pcd, irq;
    logic k_oca, k_occ, k_pe, k_pp, k_ppe, k_pcd, k_irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    usb_port_ocp #(.SYNC_STAGES(2), .CLEAR_PP_ON_OC(1'b1)) i_usb_port_ocp (
        .clk(clk), .rst_n(rst_n), .oc_ext_i(oc_ext), .cap_ppc_i(cap_ppc),
        .cfg_flag_i(cfg_flag), .pce_i(pce), .pe_wr_i(pe_wr), .pe_wdata_i(pe_wdata),
        .pp_wr_i(pp_wr), .pp_wdata_i(pp_wdata), .occ_clr_i(occ_clr), .pcd_clr_i(pcd_clr),
        .oca_o(oca), .occ_o(occ), .pe_o(pe), .pp_o(pp), .ppe_o(ppe),
        .pcd_o(pcd), .irq_o(irq)
    );

    usb_port_ocp #(.SYNC_STAGES(2), .CLEAR_PP_ON_OC(1'b0)) i_usb_port_ocp_keep (
        .clk(clk), .rst_n(rst_n), .oc_ext_i(oc_ext), .cap_ppc_i(cap_ppc),
        .cfg_flag_i(cfg_flag), .pce_i(pce), .pe_wr_i(pe_wr), .pe_wdata_i(pe_wdata),
        .pp_wr_i(pp_wr), .pp_wdata_i(pp_wdata), .occ_clr_i(occ_clr), .pcd_clr_i(pcd_clr),
        .oca_o(k_oca), .occ_o(k_occ), .pe_o(k_pe), .pp_o(k_pp), .ppe_o(k_ppe),
        .pcd_o(k_pcd), .irq_o(k_irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; oc_ext = 1'b0; cap_ppc = 1'b0; cfg_flag = 1'b0; pce = 1'b0;
        pe_wr = 1'b0; pe_wdata = 1'b0; pp_wr = 1'b0; pp_wdata = 1'b0;
        occ_clr = 1'b0; pcd_clr = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 oca", oca, 1'b0);  chk("R1 occ", occ, 1'b0);
        chk("R1 pe", pe, 1'b0);    chk("R1 pp", pp, 1'b0);
        chk("R1 pcd", pcd, 1'b0);  chk("R1 ppe", ppe, 1'b0);
        chk("R1 irq", irq, 1'b0);
    endtask

    task automatic t_power();
        pp_wr = 1'b1; pp_wdata = 1'b1; pe_wr = 1'b1; pe_wdata = 1'b1;
        step(1);
        pp_wr = 1'b0; pe_wr = 1'b0;
        chk("R8 pp write", pp, 1'b1);
        chk("R5 pe write", pe, 1'b1);
        chk("R9 ppe cap0 cfg0", ppe, 1'b1);
        cap_ppc = 1'b1; #1;
        chk("R9 ppe cap1 cfg0", ppe, 1'b0);
        cfg_flag = 1'b1; #1;
        chk("R9 ppe cap1 cfg1", ppe, 1'b1);
    endtask

    task automatic t_oc_onset();
        pce = 1'b1;
        oc_ext = 1'b1;
        step(2);
        chk("R2 oca not before edge 3", oca, 1'b0);
        chk("R3 occ not before edge 3", occ, 1'b0);
        step(1);
        chk("R2 oca after edge 3", oca, 1'b1);
        chk("R3 occ on rise", occ, 1'b1);
        chk("R5 pe dropped", pe, 1'b0);
        chk("R6 pcd set", pcd, 1'b1);
        chk("R7 irq", irq, 1'b1);
        chk("R8 pp cleared", pp, 1'b0);
        chk("R9 ppe off", ppe, 1'b0);
        chk("R8 keep pp", k_pp, 1'b1);
        chk("R8 keep ppe", k_ppe, 1'b1);
        pe_wr = 1'b1; pe_wdata = 1'b1;
        step(1);
        pe_wr = 1'b0;
        chk("R5 pe write blocked", pe, 1'b0);
    endtask

    task automatic t_clears();
        step(2);
        chk("R4 occ sticky", occ, 1'b1);
        occ_clr = 1'b1;
        step(1);
        occ_clr = 1'b0;
        chk("R4 occ cleared", occ, 1'b0);
        chk("R6 pcd kept", pcd, 1'b1);
        pce = 1'b0; #1;
        chk("R7 irq gated", irq, 1'b0);
        pce = 1'b1; #1;
        chk("R7 irq ungated", irq, 1'b1);
        pcd_clr = 1'b1;
        step(1);
        pcd_clr = 1'b0;
        chk("R6 pcd cleared", pcd, 1'b0);
        chk("R7 irq off", irq, 1'b0);
    endtask

    task automatic t_release_and_sticky();
        oc_ext = 1'b0;
        step(3);
        chk("R2 oca released", oca, 1'b0);
        chk("R3 occ on fall", occ, 1'b1);
        chk("R6 pcd on fall", pcd, 1'b1);
        pcd_clr = 1'b1;
        step(1);
        pcd_clr = 1'b0;
        chk("R6 pcd cleared again", pcd, 1'b0);
        oc_ext = 1'b1;
        step(3);
        chk("R2 oca again", oca, 1'b1);
        chk("R6 no pcd while occ held", pcd, 1'b0);
        chk("R6 keep no pcd", k_pcd, 1'b0);
    endtask

    task automatic t_collision();
        occ_clr = 1'b1; pcd_clr = 1'b1;
        step(1);
        occ_clr = 1'b0; pcd_clr = 1'b0;
        chk("R4 occ pre-clear", occ, 1'b0);
        oc_ext = 1'b0;
        step(2);
        occ_clr = 1'b1; pcd_clr = 1'b1;
        step(1);
        occ_clr = 1'b0; pcd_clr = 1'b0;
        chk("R2 oca fall", oca, 1'b0);
        chk("R4 set wins occ", occ, 1'b1);
        chk("R6 set wins pcd", pcd, 1'b1);
    endtask

    task automatic t_power_restore();
        pp_wr = 1'b1; pp_wdata = 1'b1; pe_wr = 1'b1; pe_wdata = 1'b1;
        step(1);
        pp_wr = 1'b0; pe_wr = 1'b0;
        chk("R8 pp rewritten", pp, 1'b1);
        chk("R5 pe rewritten", pe, 1'b1);
        pp_wr = 1'b1; pp_wdata = 1'b0;
        step(1);
        pp_wr = 1'b0;
        chk("R8 pp write zero", pp, 1'b0);
        chk("R9 ppe follows pp", ppe, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_power();
        t_oc_onset();
        t_clears();
        t_release_and_sticky();
        t_collision();
        t_power_restore();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule